// File: doc/BRIEF.md
# Rotational Fetch Latency Calculator

This block works out how many word times must pass before the next instruction word can be read from a rotating memory. In that memory, logical sectors are interleaved around the track. It takes four inputs: the address of the instruction that just finished, the next program counter, the operand address and the opcode. It turns each address's low bits into a physical slot on the track. It then measures the forward rotational distance from the current slot to the next instruction and to the operand. If the operand distance falls outside a per-opcode reach window, the block charges one extra revolution.

The result is registered one clock after a start strobe. On the following clock it is loaded into a down-counter. The counter steps once per word-time tick. A ready output tells the fetch logic when the wait is over. Track size, interleave step, window limits and address width are all parameters.

Top module: `rot_latency`

## Requirements
- R1: The sector of an address is its low SEC_BITS bits (6 by default, 64 slots). Logical sector s sits at physical slot (NSEC − (STEP·s mod NSEC)) mod NSEC, with STEP = 7 by default. So sectors 0, 1, 2 land on 0, 57, 50.
- R2: The fetch distance is (slot(next_pc) − slot(cur_addr)) mod NSEC. The operand distance is (slot(opnd_addr) − slot(cur_addr)) mod NSEC.
- R3: For an opcode whose maximum window is 0 (opcodes 0xA and 0xB by default), the operand address is ignored. The delay is fetch distance − 1 when the fetch distance is at least MIN_WIN (2). Otherwise it is fetch distance + NSEC − 1.
- R4: For an opcode with a nonzero maximum window, the delay is fetch distance − 1 when three conditions hold: the operand distance lies in [MIN_WIN, max], and the fetch distance is nonzero. Otherwise the delay is fetch distance + NSEC − 1. The default maxima for opcodes 0..F are 7,7,7,7,7,5,8,6,7,7,0,0,7,7,7,7.
- R5: After a clock edge that samples start high, delay_out holds the result and delay_valid is high for exactly that following cycle. Without start, delay_valid is low.
- R6: On the clock after delay_valid, count_out loads delay_out. After that it drops by one on each edge where tick is high and it is nonzero. It holds when tick is low.
- R7: ready is high exactly when count_out is zero and delay_valid is low. After reset, count_out is 0, delay_valid is 0 and ready is 1.
- R8: Address bits above the sector field have no effect on the delay.
- R9: A start that arrives while the counter is still running replaces the count with the new delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction completed; sample the addresses and opcode |
| cur_addr | input | ADDR_W | Address of the completed instruction |
| next_pc | input | ADDR_W | Address of the next instruction |
| opnd_addr | input | ADDR_W | Operand address of the completed instruction |
| opcode | input | OPC_W | Opcode of the completed instruction |
| tick | input | 1 | One pulse per word time |
| delay_out | output | SEC_BITS+1 | Registered delay in word times |
| delay_valid | output | 1 | delay_out was computed on the last edge |
| count_out | output | SEC_BITS+1 | Remaining word times before fetch |
| ready | output | 1 | Next fetch may proceed |

## Verification
A wrong slot mapping or a wrong distance shows up as a wrong delay_out one cycle after start. An error in the window table or the window compare shows up the same way, and usually as an extra or missing 64 word times. A corrupted counter state shows on count_out on the very next edge after the load or the tick that caused it. It then shows on ready at the moment the wait should end, so a sweep of opcodes, slot pairs and operand positions plus timed countdowns reaches every path within a few cycles of the fault.

// File: rtl/rot_latency_pkg.sv
package rot_latency_pkg;

   // Forward distance around a track whose size is a power of two.
   function automatic logic [15:0] ring_dist(input logic [15:0] to_slot,
                                             input logic [15:0] from_slot,
                                             input int unsigned bits);
      logic [15:0] diff;
      diff = to_slot - from_slot;
      return diff & ((16'd1 << bits) - 16'd1);
   endfunction

   typedef enum logic [1:0] {
      MAP_INTERLEAVED = 2'd0,
      MAP_LINEAR      = 2'd1
   } map_kind_e;

endpackage

// File: rtl/rot_sector_map.sv
module rot_sector_map #(
   parameter int unsigned SEC_BITS = 6,
   parameter int unsigned STEP     = 7
) (
   input  logic [SEC_BITS-1:0] logical_sec,
   output logic [SEC_BITS-1:0] physical_slot
);
   import rot_latency_pkg::*;

   localparam map_kind_e KIND = (STEP == 0) ? MAP_LINEAR : MAP_INTERLEAVED;
   localparam int unsigned PW = 2 * SEC_BITS + 8;

   generate
      if (KIND == MAP_LINEAR) begin : g_linear
         assign physical_slot = logical_sec;
      end else begin : g_interleave
         logic [PW-1:0] prod;
         logic [SEC_BITS-1:0] prod_mod;
         assign prod          = PW'(logical_sec) * PW'(STEP);
         assign prod_mod      = prod[SEC_BITS-1:0];
         // negation modulo the track size
         assign physical_slot = SEC_BITS'(~prod_mod + 1'b1);
      end
   endgenerate
endmodule

// File: rtl/rot_window_rom.sv
module rot_window_rom #(
   parameter int unsigned OPC_W   = 4,
   parameter int unsigned WIN_W   = 4,
   parameter logic [(1<<OPC_W)*WIN_W-1:0] MAX_WIN = '0
) (
   input  logic [OPC_W-1:0] opcode,
   output logic [WIN_W-1:0] max_win,
   output logic             op_blind
);
   localparam int unsigned NOPC = 1 << OPC_W;

   logic [WIN_W-1:0] entries [NOPC];

   generate
      for (genvar i = 0; i < NOPC; i++) begin : g_entry
         assign entries[i] = MAX_WIN[i*WIN_W +: WIN_W];
      end
   endgenerate

   assign max_win  = entries[opcode];
   assign op_blind = (max_win == '0);
endmodule

// File: rtl/rot_delay_calc.sv
module rot_delay_calc #(
   parameter int unsigned SEC_BITS = 6,
   parameter int unsigned WIN_W    = 4,
   parameter int unsigned MIN_WIN  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [SEC_BITS-1:0] cur_slot,
   input  logic [SEC_BITS-1:0] next_slot,
   input  logic [SEC_BITS-1:0] opnd_slot,
   input  logic [WIN_W-1:0]    max_win,
   input  logic                op_blind,
   output logic [SEC_BITS:0]   delay_q,
   output logic                valid_q
);
   import rot_latency_pkg::*;

   localparam int unsigned NSEC  = 1 << SEC_BITS;
   localparam int unsigned DLY_W = SEC_BITS + 1;

   logic [SEC_BITS-1:0] fetch_dist;
   logic [SEC_BITS-1:0] opnd_dist;
   logic                opnd_in_reach;
   logic                same_turn;
   logic [DLY_W-1:0]    delay_d;

   assign fetch_dist = SEC_BITS'(ring_dist(16'(next_slot), 16'(cur_slot), SEC_BITS));
   assign opnd_dist  = SEC_BITS'(ring_dist(16'(opnd_slot), 16'(cur_slot), SEC_BITS));

   assign opnd_in_reach = (32'(opnd_dist) >= MIN_WIN) &&
                          (32'(opnd_dist) <= 32'(max_win));

   always_comb begin
      if (op_blind) begin
         same_turn = (32'(fetch_dist) >= MIN_WIN);
      end else begin
         same_turn = opnd_in_reach && (fetch_dist != '0);
      end
      if (same_turn) begin
         delay_d = DLY_W'(fetch_dist) - DLY_W'(1);
      end else begin
         delay_d = DLY_W'(fetch_dist) + DLY_W'(NSEC - 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         delay_q <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= start;
         if (start) begin
            delay_q <= delay_d;
         end
      end
   end
endmodule

// File: rtl/rot_countdown.sv
module rot_countdown #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             is_zero
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (tick && (count != '0)) begin
         count <= count - CNT_W'(1);
      end
   end

   assign is_zero = (count == '0);
endmodule

// File: rtl/rot_latency.sv
module rot_latency #(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned SEC_BITS = 6,
   parameter int unsigned STEP     = 7,
   parameter int unsigned OPC_W    = 4,
   parameter int unsigned WIN_W    = 4,
   parameter int unsigned MIN_WIN  = 2,
   parameter logic [(1<<OPC_W)*WIN_W-1:0] MAX_WIN = 64'h7777_0077_6857_7777
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   cur_addr,
   input  logic [ADDR_W-1:0]   next_pc,
   input  logic [ADDR_W-1:0]   opnd_addr,
   input  logic [OPC_W-1:0]    opcode,
   input  logic                tick,
   output logic [SEC_BITS:0]   delay_out,
   output logic                delay_valid,
   output logic [SEC_BITS:0]   count_out,
   output logic                ready
);
   localparam int unsigned NSEC  = 1 << SEC_BITS;
   localparam int unsigned DLY_W = SEC_BITS + 1;
   localparam int unsigned NADDR = 3;

   generate
      if (SEC_BITS > ADDR_W) begin : g_bad_width
         $error("sector field wider than address");
      end
      if (SEC_BITS < 2 || SEC_BITS > 12) begin : g_bad_track
         $error("track size out of supported range");
      end
      if (STEP != 0 && (STEP % 2) == 0) begin : g_bad_step
         $error("interleave step must be odd to cover every slot");
      end
      if (MIN_WIN < 1 || MIN_WIN >= NSEC) begin : g_bad_min
         $error("minimum window must lie in 1..NSEC-1");
      end
   endgenerate

   logic [SEC_BITS-1:0] log_sec  [NADDR];
   logic [SEC_BITS-1:0] phys_sec [NADDR];

   assign log_sec[0] = cur_addr[SEC_BITS-1:0];
   assign log_sec[1] = next_pc[SEC_BITS-1:0];
   assign log_sec[2] = opnd_addr[SEC_BITS-1:0];

   generate
      for (genvar k = 0; k < NADDR; k++) begin : g_map
         rot_sector_map #(
            .SEC_BITS (SEC_BITS),
            .STEP     (STEP)
         ) map_i (
            .logical_sec   (log_sec[k]),
            .physical_slot (phys_sec[k])
         );
      end
   endgenerate

   logic [WIN_W-1:0] max_win;
   logic             op_blind;

   rot_window_rom #(
      .OPC_W   (OPC_W),
      .WIN_W   (WIN_W),
      .MAX_WIN (MAX_WIN)
   ) rom_i (
      .opcode   (opcode),
      .max_win  (max_win),
      .op_blind (op_blind)
   );

   rot_delay_calc #(
      .SEC_BITS (SEC_BITS),
      .WIN_W    (WIN_W),
      .MIN_WIN  (MIN_WIN)
   ) calc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cur_slot  (phys_sec[0]),
      .next_slot (phys_sec[1]),
      .opnd_slot (phys_sec[2]),
      .max_win   (max_win),
      .op_blind  (op_blind),
      .delay_q   (delay_out),
      .valid_q   (delay_valid)
   );

   logic cnt_zero;

   rot_countdown #(
      .CNT_W (DLY_W)
   ) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (delay_valid),
      .load_val (delay_out),
      .tick     (tick),
      .count    (count_out),
      .is_zero  (cnt_zero)
   );

   assign ready = cnt_zero && !delay_valid;
endmodule

// File: rtl/rot_latency_chk.sv
module rot_latency_chk #(
   parameter int unsigned SEC_BITS = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              tick,
   input logic [SEC_BITS:0] delay_out,
   input logic              delay_valid,
   input logic [SEC_BITS:0] count_out,
   input logic              ready
);
   localparam int unsigned NSEC = 1 << SEC_BITS;

   a_r5_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> delay_valid);

   a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !delay_valid);

   a_r4_delay_bound: assert property (@(posedge clk) disable iff (!rst_n)
      delay_valid |-> (32'(delay_out) <= 2 * NSEC - 2));

   a_r6_load_count: assert property (@(posedge clk) disable iff (!rst_n)
      delay_valid |=> (count_out == $past(delay_out)));

   a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!delay_valid && !tick) |=> $stable(count_out));

   a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!delay_valid && tick && count_out != '0) |=>
         (count_out == $past(count_out) - 1'b1));

   a_r7_busy_when_loading: assert property (@(posedge clk) disable iff (!rst_n)
      delay_valid |-> !ready);

   a_r7_busy_when_counting: assert property (@(posedge clk) disable iff (!rst_n)
      (count_out != '0) |-> !ready);
endmodule

bind rot_latency rot_latency_chk #(
   .SEC_BITS (SEC_BITS)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .tick        (tick),
   .delay_out   (delay_out),
   .delay_valid (delay_valid),
   .count_out   (count_out),
   .ready       (ready)
);

// File: tb/rot_latency_tb_top.sv
module rot_latency_tb_top;
   localparam int ADDR_W = 12;
   localparam int SB     = 6;
   localparam int NS     = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] cur_addr = '0;
   logic [ADDR_W-1:0] next_pc = '0;
   logic [ADDR_W-1:0] opnd_addr = '0;
   logic [3:0]        opcode = '0;
   logic              tick = 1'b0;
   logic [SB:0]       delay_out;
   logic              delay_valid;
   logic [SB:0]       count_out;
   logic              ready;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rot_latency dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cur_addr(cur_addr),
      .next_pc(next_pc), .opnd_addr(opnd_addr), .opcode(opcode),
      .tick(tick), .delay_out(delay_out), .delay_valid(delay_valid),
      .count_out(count_out), .ready(ready)
   );

   function automatic int slot_of(input int s);
      return (NS - ((7 * s) % NS)) % NS;
   endfunction

   function automatic int reach_of(input int op);
      case (op)
         5:       return 5;
         6:       return 8;
         7:       return 6;
         10, 11:  return 0;
         default: return 7;
      endcase
   endfunction

   function automatic int model_delay(input int op, input int c, input int n, input int o);
      int pd, od, mx;
      bit near;
      pd = (slot_of(n) - slot_of(c) + NS) % NS;
      od = (slot_of(o) - slot_of(c) + NS) % NS;
      mx = reach_of(op);
      if (mx == 0) near = (pd >= 2);
      else         near = (od >= 2) && (od <= mx) && (pd != 0);
      return near ? pd - 1 : pd + NS - 1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Apply one start; hi bits are placed above the sector field.
   task automatic calc(input int op, input int c, input int n, input int o,
                       input int hi, input string req);
      int exp;
      @(negedge clk);
      opcode    = 4'(op);
      cur_addr  = ADDR_W'((hi << SB) | c);
      next_pc   = ADDR_W'((((hi * 5) & 63) << SB) | n);
      opnd_addr = ADDR_W'((((hi * 3) & 63) << SB) | o);
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      exp = model_delay(op, c, n, o);
      check(delay_valid == 1'b1, "R5", int'(delay_valid), 1);
      check(int'(delay_out) == exp, req, int'(delay_out), exp);
   endtask

   initial begin
      int exp;
      #1;
      check(ready == 1'b1, "R7 reset ready", int'(ready), 1);
      check(count_out == '0, "R7 reset count", int'(count_out), 0);
      check(delay_valid == 1'b0, "R7 reset valid", int'(delay_valid), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(delay_valid == 1'b0, "R5 idle", int'(delay_valid), 0);

      // R1 mapping seen through window-free opcode: cur 0, next 1 -> slot 57 -> 56
      calc(10, 0, 1, 0, 0, "R1");
      calc(10, 0, 2, 0, 0, "R1");
      // R3 short fetch distance: next slot 1 -> 64
      calc(10, 0, 9, 0, 0, "R3");

      // R2/R3/R4/R8 sweep over opcodes, current slots and next slots
      for (int op = 0; op < 16; op++)
         for (int c = 0; c < NS; c += 3)
            for (int n = 0; n < NS; n++)
               calc(op, c, n, (c + n * 5 + op) % NS, (op + n) & 63,
                    (reach_of(op) == 0) ? "R3" : "R4");

      // Operand sweep: every operand slot for every opcode
      for (int op = 0; op < 16; op++)
         for (int o = 0; o < NS; o++)
            calc(op, 5, 31, o, o & 63, (reach_of(op) == 0) ? "R3 operand ignored" : "R4");

      // R4 same-slot next pc forces full revolution
      calc(1, 4, 4, 20, 0, "R4");

      // R8: only the high bits change
      calc(3, 12, 40, 13, 0, "R8");
      calc(3, 12, 40, 13, 63, "R8");

      // R6/R7 countdown
      exp = model_delay(10, 0, 45, 0);
      @(negedge clk);
      tick = 1'b1;
      opcode = 4'd10; cur_addr = 0; next_pc = 45; opnd_addr = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(ready == 1'b0, "R7 busy while loading", int'(ready), 0);
      @(negedge clk);
      check(int'(count_out) == exp, "R6 load", int'(count_out), exp);
      tick = 1'b0;
      repeat (3) @(negedge clk);
      check(int'(count_out) == exp, "R6 hold", int'(count_out), exp);
      check(ready == 1'b0, "R7 busy", int'(ready), 0);
      tick = 1'b1;
      for (int i = 1; i <= exp; i++) begin
         @(negedge clk);
         check(int'(count_out) == exp - i, "R6 step", int'(count_out), exp - i);
         check(ready == (i == exp), "R7 ready", int'(ready), int'(i == exp));
      end
      @(negedge clk);
      check(count_out == '0, "R6 stays zero", int'(count_out), 0);

      // R9 reload mid-count
      opcode = 4'd10; cur_addr = 0; next_pc = 1; opnd_addr = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      exp = model_delay(10, 0, 45, 0);
      next_pc = 45;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check(int'(count_out) == exp, "R9 reload", int'(count_out), exp);
      tick = 1'b0;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule